// File: doc/BRIEF.md
# In-Order Dispatch Group Former

This block holds decoded instructions in a small circular queue and, every cycle, builds a dispatch group of up to four from the head of that queue. Each instruction carries a two-bit class tag. The group must fit a mix of execution slots: at most two integer operations, and at most two floating-point or graphics operations combined, of which at most one may be graphics. The scan runs strictly in program order. It ends at the first instruction that does not fit, so no later instruction overtakes an earlier one. Dependency checking between members of a group is left to other logic.

The front end pushes up to two instructions per cycle into lanes 0 and 1. The back end sees a four-slot dispatch vector with valid bits and an advance count. When the downstream stall input is low, the queue drops exactly the advance count of entries at the next clock edge. When stall is high, nothing leaves the queue, nothing enters it, and the presented group stays unchanged.

Top module: `dispatch_grouper`

## Requirements
- R1: Slot i of the dispatch vector carries the class and data of the i-th oldest queued instruction, for every valid slot. A group never holds more than four instructions.
- R2: A group contains at most two instructions of class 0 (integer).
- R3: A group contains at most two instructions whose class is not 0 (floating-point, class 1, or graphics, class 2 or 3) in total.
- R4: A group contains at most one graphics instruction (class code with bit 1 set). Two floating-point instructions are allowed together, and so are one floating-point and one graphics instruction.
- R5: The group ends at the first queued instruction that would break R2 to R4. Valid bits are contiguous from slot 0, and later instructions are never pulled forward. Slots that are not valid drive zero class and zero data.
- R6: With fewer than four instructions queued, the group is formed from those present. An empty queue gives no valid slot and an advance count of 0.
- R7: The advance count equals the number of valid slots. With stall low, the queue loses exactly that many oldest entries at the clock edge.
- R8: While stall is high, the queue is neither popped nor written. The slot valid bits, classes and data in the following cycle equal those in the current one.
- R9: push_ready is high exactly when stall is low and at least two queue entries are free. Accepted lanes enter behind all earlier entries, lane 0 before lane 1.
- R10: After reset the queue is empty, no slot is valid, the advance count is 0 and push_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | PUSH_W | Per-lane write request; lane 1 is used only together with lane 0 |
| push_cls | input | 2*PUSH_W | Per-lane class code (0 integer, 1 floating-point, 2 or 3 graphics) |
| push_data | input | DW*PUSH_W | Per-lane instruction payload |
| push_ready | output | 1 | Queue accepts this cycle's lanes |
| stall | input | 1 | Downstream stall; holds the group and the queue |
| slot_valid | output | GW | Valid bit per dispatch slot |
| slot_cls | output | 2*GW | Class code per dispatch slot |
| slot_data | output | DW*GW | Payload per dispatch slot |
| advance | output | clog2(GW+1) | Number of instructions dispatched by this group |

## Verification
The assertions assume that push lanes are used contiguously: lane 1 never requests a write without lane 0. They also assume that pushes are made only while push_ready is high, so the queue cannot overflow. The bench only drives lane patterns of none, lane 0, or both lanes. It compares results against a model that accepts lanes only when its own occupancy allows. A graphics-heavy class mix keeps the queue near full, so refusal of writes is exercised. A random stall of about one cycle in six exercises the hold behaviour.

// File: rtl/dg_pkg.sv
// Shared class encoding and helpers for the dispatch group former.
// Assumes a two-bit class tag travels with every queued instruction.
package dg_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_GFX = 2'd2,
        CLS_GX2 = 2'd3
    } cls_e;

    // True when the class needs an integer slot.
    function automatic logic needs_int(input logic [1:0] c);
        return c == CLS_INT;
    endfunction

    // True when the class uses the graphics unit (bit 1 set).
    function automatic logic needs_gfx(input logic [1:0] c);
        return c[1];
    endfunction

endpackage

// File: rtl/dg_queue.sv
// Circular instruction queue with a multi-lane write port and a head window.
// Exposes the WIN oldest entries combinationally and pops a variable count.
// Assumes DEPTH is a power of two, WIN <= DEPTH, and lanes are used
// contiguously from lane 0. Writes are only made when room is reported.
module dg_queue #(
    parameter int DEPTH  = 8,
    parameter int PUSH_W = 2,
    parameter int WIN    = 4,
    parameter int DW     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PUSH_W-1:0]             wr_en,
    input  logic [PUSH_W-1:0][1:0]        wr_cls,
    input  logic [PUSH_W-1:0][DW-1:0]     wr_data,
    input  logic [$clog2(WIN+1)-1:0]      rd_n,
    output logic [WIN-1:0]                win_v,
    output logic [WIN-1:0][1:0]           win_cls,
    output logic [WIN-1:0][DW-1:0]        win_data,
    output logic                          room
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [1:0]    cls_q [DEPTH];
    logic [DW-1:0] dat_q [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic [AW-1:0] lane_addr [PUSH_W];
    logic [CW-1:0] wr_n;

    // Assign each active lane the next free address in lane order.
    always_comb begin
        logic [AW-1:0] run;
        run  = '0;
        wr_n = '0;
        for (int k = 0; k < PUSH_W; k++) begin
            lane_addr[k] = wr_ptr + run;
            if (wr_en[k]) begin
                run  = run + AW'(1);
                wr_n = wr_n + CW'(1);
            end
        end
    end

    // Payload storage; contents are don't-care until written, so no reset.
    always_ff @(posedge clk) begin
        for (int k = 0; k < PUSH_W; k++) begin
            if (wr_en[k]) begin
                cls_q[lane_addr[k]] <= wr_cls[k];
                dat_q[lane_addr[k]] <= wr_data[k];
            end
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            rd_ptr <= rd_ptr + AW'(rd_n);
            wr_ptr <= wr_ptr + AW'(wr_n);
            cnt    <= cnt + wr_n - CW'(rd_n);
        end
    end

    // Head window: entry i is valid while more than i entries are held.
    for (genvar i = 0; i < WIN; i++) begin : g_win
        logic [AW-1:0] idx;
        assign idx         = rd_ptr + AW'(i);
        assign win_v[i]    = cnt > CW'(i);
        assign win_cls[i]  = cls_q[idx];
        assign win_data[i] = dat_q[idx];
    end

    // Room for a full set of lanes next cycle.
    assign room = cnt <= CW'(DEPTH - PUSH_W);

endmodule

// File: rtl/dg_group_former.sv
// In-order slot-mix scan over the queue head window.
// Accepts entries from the oldest onward while the integer, shared
// FP/graphics and graphics budgets hold; the first misfit ends the group.
// Assumes win_v is contiguous from entry 0.
module dg_group_former
    import dg_pkg::*;
#(
    parameter int WIN     = 4,
    parameter int MAX_INT = 2,
    parameter int MAX_FPG = 2,
    parameter int MAX_GFX = 1
) (
    input  logic [WIN-1:0]           win_v,
    input  logic [WIN-1:0][1:0]      win_cls,
    output logic [WIN-1:0]           take,
    output logic [$clog2(WIN+1)-1:0] take_n
);

    localparam int NW = $clog2(WIN+1);

    logic [NW-1:0] n_int [WIN+1];
    logic [NW-1:0] n_fpg [WIN+1];
    logic [NW-1:0] n_gfx [WIN+1];
    logic [WIN:0]  chain;

    assign n_int[0] = '0;
    assign n_fpg[0] = '0;
    assign n_gfx[0] = '0;
    assign chain[0] = 1'b1;

    // One scan stage per window entry, carrying the running slot usage.
    for (genvar i = 0; i < WIN; i++) begin : g_scan
        logic is_int, is_fpg, is_gfx, fits;
        assign is_int = needs_int(win_cls[i]);
        assign is_gfx = needs_gfx(win_cls[i]);
        assign is_fpg = !is_int;
        assign fits   = (!is_int || (n_int[i] < NW'(MAX_INT)))
                     && (!is_fpg || (n_fpg[i] < NW'(MAX_FPG)))
                     && (!is_gfx || (n_gfx[i] < NW'(MAX_GFX)));
        assign chain[i+1]  = chain[i] & win_v[i] & fits;
        assign take[i]     = chain[i+1];
        assign n_int[i+1]  = n_int[i] + NW'(take[i] & is_int);
        assign n_fpg[i+1]  = n_fpg[i] + NW'(take[i] & is_fpg);
        assign n_gfx[i+1]  = n_gfx[i] + NW'(take[i] & is_gfx);
    end

    // Group size is the length of the accepted prefix.
    always_comb begin
        take_n = '0;
        for (int i = 0; i < WIN; i++) begin
            take_n = take_n + NW'(take[i]);
        end
    end

endmodule

// File: rtl/dg_slot_drive.sv
// Drives the flattened dispatch vector from the head window.
// Slots outside the accepted group are forced to zero.
module dg_slot_drive #(
    parameter int GW = 4,
    parameter int DW = 16
) (
    input  logic [GW-1:0]          take,
    input  logic [GW-1:0][1:0]     win_cls,
    input  logic [GW-1:0][DW-1:0]  win_data,
    output logic [GW-1:0]          slot_valid,
    output logic [2*GW-1:0]        slot_cls,
    output logic [DW*GW-1:0]       slot_data
);

    // Per-slot gating of class and payload by the take bit.
    for (genvar i = 0; i < GW; i++) begin : g_slot
        assign slot_valid[i]          = take[i];
        assign slot_cls[2*i +: 2]     = take[i] ? win_cls[i]  : 2'b00;
        assign slot_data[DW*i +: DW]  = take[i] ? win_data[i] : '0;
    end

endmodule

// File: rtl/dispatch_grouper.sv
// Top of the dispatch group former: instruction queue, in-order slot-mix
// scan and dispatch vector. Stall freezes both pop and push so the
// presented group is held. Assumes lane 1 is never used without lane 0.
module dispatch_grouper #(
    parameter int DW      = 16,
    parameter int DEPTH   = 8,
    parameter int PUSH_W  = 2,
    parameter int GW      = 4,
    parameter int MAX_INT = 2,
    parameter int MAX_FPG = 2,
    parameter int MAX_GFX = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PUSH_W-1:0]           push_valid,
    input  logic [2*PUSH_W-1:0]         push_cls,
    input  logic [DW*PUSH_W-1:0]        push_data,
    output logic                        push_ready,
    input  logic                        stall,
    output logic [GW-1:0]               slot_valid,
    output logic [2*GW-1:0]             slot_cls,
    output logic [DW*GW-1:0]            slot_data,
    output logic [$clog2(GW+1)-1:0]     advance
);

    localparam int NW = $clog2(GW+1);

    logic [PUSH_W-1:0]          wr_en;
    logic [PUSH_W-1:0][1:0]     wr_cls;
    logic [PUSH_W-1:0][DW-1:0]  wr_data;
    logic [GW-1:0]              win_v;
    logic [GW-1:0][1:0]         win_cls;
    logic [GW-1:0][DW-1:0]      win_data;
    logic [GW-1:0]              take;
    logic [NW-1:0]              take_n;
    logic [NW-1:0]              pop_n;
    logic                       room;

    // Unpack the flat lane ports and qualify them with the ready.
    for (genvar k = 0; k < PUSH_W; k++) begin : g_lane
        assign wr_en[k]   = push_valid[k] & push_ready;
        assign wr_cls[k]  = push_cls[2*k +: 2];
        assign wr_data[k] = push_data[DW*k +: DW];
    end

    // Writes are refused while stalled so the group cannot change.
    assign push_ready = room & !stall;
    // Pop the dispatched count only when downstream accepts.
    assign pop_n      = stall ? '0 : take_n;
    assign advance    = take_n;

    dg_queue #(
        .DEPTH  (DEPTH),
        .PUSH_W (PUSH_W),
        .WIN    (GW),
        .DW     (DW)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_cls   (wr_cls),
        .wr_data  (wr_data),
        .rd_n     (pop_n),
        .win_v    (win_v),
        .win_cls  (win_cls),
        .win_data (win_data),
        .room     (room)
    );

    dg_group_former #(
        .WIN     (GW),
        .MAX_INT (MAX_INT),
        .MAX_FPG (MAX_FPG),
        .MAX_GFX (MAX_GFX)
    ) u_former (
        .win_v   (win_v),
        .win_cls (win_cls),
        .take    (take),
        .take_n  (take_n)
    );

    dg_slot_drive #(
        .GW (GW),
        .DW (DW)
    ) u_drive (
        .take       (take),
        .win_cls    (win_cls),
        .win_data   (win_data),
        .slot_valid (slot_valid),
        .slot_cls   (slot_cls),
        .slot_data  (slot_data)
    );

endmodule

// File: rtl/dg_checker.sv
// Property checker for dispatch_grouper, attached by bind below.
// Assumes contiguous lane use and pushes only while ready.
module dg_checker #(
    parameter int DW      = 16,
    parameter int PUSH_W  = 2,
    parameter int GW      = 4,
    parameter int MAX_INT = 2,
    parameter int MAX_FPG = 2,
    parameter int MAX_GFX = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stall,
    input logic                     push_ready,
    input logic [GW-1:0]            slot_valid,
    input logic [2*GW-1:0]          slot_cls,
    input logic [DW*GW-1:0]         slot_data,
    input logic [$clog2(GW+1)-1:0]  advance
);

    int  c_int, c_fpg, c_gfx;
    logic gapless, idle_zero;

    // Tally slot usage of the presented group and check slot shape.
    always_comb begin
        c_int = 0; c_fpg = 0; c_gfx = 0;
        gapless = 1'b1; idle_zero = 1'b1;
        for (int i = 0; i < GW; i++) begin
            if (slot_valid[i]) begin
                if (slot_cls[2*i +: 2] == 2'b00) c_int++;
                else c_fpg++;
                if (slot_cls[2*i+1]) c_gfx++;
            end else if (slot_cls[2*i +: 2] != 2'b00 || slot_data[DW*i +: DW] != '0) begin
                idle_zero = 1'b0;
            end
            if (i > 0 && slot_valid[i] && !slot_valid[i-1]) gapless = 1'b0;
        end
    end

    AST_INT_LIMIT:   assert property (@(posedge clk) disable iff (!rst_n) c_int <= MAX_INT); // R2
    AST_FPG_LIMIT:   assert property (@(posedge clk) disable iff (!rst_n) c_fpg <= MAX_FPG); // R3
    AST_GFX_LIMIT:   assert property (@(posedge clk) disable iff (!rst_n) c_gfx <= MAX_GFX); // R4
    AST_GAPLESS:     assert property (@(posedge clk) disable iff (!rst_n) gapless && idle_zero); // R5
    AST_ADV_COUNT:   assert property (@(posedge clk) disable iff (!rst_n) advance == $countones(slot_valid)); // R7
    AST_STALL_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                         stall |=> ($stable(slot_valid) && $stable(slot_cls) && $stable(slot_data))); // R8
    AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n) stall |-> !push_ready); // R9

endmodule

bind dispatch_grouper dg_checker #(
    .DW      (DW),
    .PUSH_W  (PUSH_W),
    .GW      (GW),
    .MAX_INT (MAX_INT),
    .MAX_FPG (MAX_FPG),
    .MAX_GFX (MAX_GFX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .push_ready (push_ready),
    .slot_valid (slot_valid),
    .slot_cls   (slot_cls),
    .slot_data  (slot_data),
    .advance    (advance)
);

// File: tb/tb_dispatch_grouper.sv
module tb_dispatch_grouper;

    localparam int CLK_PERIOD = 10;
    localparam int DW     = 16;
    localparam int DEPTH  = 8;
    localparam int PUSH_W = 2;
    localparam int GW     = 4;
    localparam int WD_CYCLES = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        push_valid = '0;
    logic [3:0]        push_cls = '0;
    logic [31:0]       push_data = '0;
    logic              push_ready;
    logic              stall = 1'b0;
    logic [3:0]        slot_valid;
    logic [7:0]        slot_cls;
    logic [63:0]       slot_data;
    logic [2:0]        advance;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] seq = 16'h0100;

    logic [17:0] mq [$];
    logic [3:0]  e_valid;
    logic [7:0]  e_cls;
    logic [63:0] e_data;
    int          e_adv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispatch_grouper dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_cls(push_cls),
        .push_data(push_data), .push_ready(push_ready), .stall(stall),
        .slot_valid(slot_valid), .slot_cls(slot_cls), .slot_data(slot_data),
        .advance(advance)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected group from the model queue under the slot-mix rules.
    task automatic model_group();
        int ni, nf, ng;
        bit open;
        ni = 0; nf = 0; ng = 0; open = 1'b1;
        e_valid = '0; e_cls = '0; e_data = '0; e_adv = 0;
        for (int i = 0; i < GW; i++) begin
            if (open && i < mq.size()) begin
                logic [1:0] c;
                bit fi, fg;
                c  = mq[i][17:16];
                fi = (c == 2'd0);
                fg = c[1];
                if ((fi && ni >= 2) || (!fi && nf >= 2) || (fg && ng >= 1)) begin
                    open = 1'b0;
                end else begin
                    if (fi) ni++; else nf++;
                    if (fg) ng++;
                    e_valid[i] = 1'b1;
                    e_cls[2*i +: 2]   = c;
                    e_data[16*i +: 16] = mq[i][15:0];
                    e_adv++;
                end
            end else begin
                open = 1'b0;
            end
        end
    endtask

    // Compare every output against the model; tag names the valid-bit check.
    task automatic cmp(input string tag);
        bit exp_ready;
        model_group();
        exp_ready = (mq.size() <= DEPTH - PUSH_W) && !stall;
        chk(slot_valid == e_valid, tag, "slot_valid", 64'(slot_valid), 64'(e_valid));
        chk(slot_cls == e_cls, "R1", "slot_cls", 64'(slot_cls), 64'(e_cls));
        chk(slot_data == e_data, "R1", "slot_data", slot_data, e_data);
        chk(int'(advance) == e_adv, "R7", "advance", 64'(advance), 64'(e_adv));
        chk(push_ready == exp_ready, "R9", "push_ready", 64'(push_ready), 64'(exp_ready));
    endtask

    // One cycle: check at the negedge, drive inputs, advance the model.
    task automatic step(input string tag, input logic [1:0] pv,
                        input logic [1:0] c0, input logic [1:0] c1, input bit st);
        bit rdy;
        logic [15:0] d0, d1;
        cmp(stall ? "R8" : tag);
        d0 = seq; d1 = seq + 16'd1; seq = seq + 16'd2;
        push_valid = pv;
        push_cls   = {c1, c0};
        push_data  = {d1, d0};
        stall      = st;
        rdy = (mq.size() <= DEPTH - PUSH_W) && !st;
        if (!st) begin
            for (int k = 0; k < e_adv; k++) void'(mq.pop_front());
        end
        if (rdy && pv[0]) mq.push_back({c0, d0});
        if (rdy && pv[1]) mq.push_back({c1, d1});
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        cmp("R10");                       // R10 during reset
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R10");                       // R10 after release
        step("R6", 2'b00, 2'd0, 2'd0, 1'b0);  // R6 empty queue
        step("R6", 2'b01, 2'd1, 2'd0, 1'b0);  // single entry
        step("R6", 2'b00, 2'd0, 2'd0, 1'b0);
        // R4: two graphics never share a group
        step("R4", 2'b11, 2'd2, 2'd3, 1'b0);
        step("R4", 2'b11, 2'd1, 2'd2, 1'b0);
        step("R4", 2'b00, 2'd0, 2'd0, 1'b0);
        step("R4", 2'b00, 2'd0, 2'd0, 1'b0);
        step("R4", 2'b00, 2'd0, 2'd0, 1'b0);
        // R2: integer budget with a graphics blocker filling the queue
        step("R2", 2'b11, 2'd2, 2'd2, 1'b0);
        step("R2", 2'b11, 2'd0, 2'd0, 1'b0);
        step("R2", 2'b11, 2'd0, 2'd1, 1'b0);
        for (int i = 0; i < 4; i++) step("R2", 2'b00, 2'd0, 2'd0, 1'b0);
        // R3/R5: shared FP budget, later integer not pulled forward
        step("R3", 2'b11, 2'd2, 2'd2, 1'b0);
        step("R3", 2'b11, 2'd1, 2'd1, 1'b0);
        step("R5", 2'b11, 2'd1, 2'd0, 1'b0);
        for (int i = 0; i < 4; i++) step("R3", 2'b00, 2'd0, 2'd0, 1'b0);
        // R9: graphics-only stream fills the queue
        for (int i = 0; i < 8; i++) step("R9", 2'b11, 2'd2, 2'd3, 1'b0);
        // R8: hold under stall with pushes attempted
        for (int i = 0; i < 4; i++) step("R8", 2'b11, 2'd0, 2'd1, 1'b1);
        for (int i = 0; i < 6; i++) step("R1", 2'b00, 2'd0, 2'd0, 1'b0);
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] pv, c0, c1;
            int r;
            r  = int'($urandom % 3);
            pv = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
            r  = int'($urandom % 8);
            c0 = (r < 3) ? 2'd0 : (r < 5) ? 2'd1 : (r < 7) ? 2'd2 : 2'd3;
            r  = int'($urandom % 8);
            c1 = (r < 3) ? 2'd0 : (r < 5) ? 2'd1 : (r < 7) ? 2'd2 : 2'd3;
            step("R5", pv, c0, c1, ($urandom % 6) == 0);
        end
        for (int i = 0; i < 8; i++) step("R6", 2'b00, 2'd0, 2'd0, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule